// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block produces the bus control waveforms for the instruction-fetch machine cycle of an 8-bit processor. A start request, accepted only while the sequencer is idle, launches a cycle of four clock states. Wait states can be inserted between the second and third states. In the first half of the cycle the program counter goes out on the address bus. The fetch indicator, memory request and read strobes frame an ordinary memory read, and the opcode is captured from the data bus. In the second half the same memory request strobe is reused as a dynamic-memory refresh strobe. During that phase the address bus carries a 7-bit refresh row, and the refresh indicator is active. The refresh row advances once per completed cycle.

The state machine has six states. IDLE goes to T1 when start is high. T1 goes to T2. T2 and TW each go to TW if the stall sample taken on the falling edge inside them was active, and to T3 otherwise. T3 goes to T4, and T4 returns to IDLE. The state advances on rising edges. A copy of the state taken on falling edges gives the half-clock placement of memory request and read. All strobes are active-low. A one-cycle done pulse marks the end of a cycle, and the captured opcode is valid while that pulse is high.

Top module: `opfetch_seq`

## Requirements
- R1: While reset is high, and in IDLE after reset, fetch_n, mem_req_n, rd_stb_n and refresh_n are all 1, done is 0 and addr is 0.
- R2: From the rising edge that starts T1, addr equals the pc value sampled at that edge and fetch_n is 0. mem_req_n and rd_stb_n stay 1 for the first half of T1.
- R3: mem_req_n and rd_stb_n go to 0 on the falling edge inside T1 and stay 0 through T2 and every wait state. fetch_n stays 0 and refresh_n stays 1 during this time.
- R4: stall_n is sampled on the falling edge inside T2 and inside each wait state. A sample of 0 inserts one more wait state, and a sample of 1 lets T3 follow at the next rising edge.
- R5: On the rising edge that starts T3, din is captured as the opcode, and fetch_n, rd_stb_n and mem_req_n return to 1. Later changes on din do not alter the captured opcode.
- R6: During T3 and T4, refresh_n is 0, rd_stb_n is 1, and addr equals the 7-bit refresh count in bits 6:0, with every bit above bit 6 at 0. addr does not change during T3 and T4.
- R7: In the refresh phase, mem_req_n goes to 0 on the falling edge inside T3 and returns to 1 on the falling edge inside T4.
- R8: done is 1 for exactly the one cycle after T4, and opcode then holds the captured byte. The refresh count then advances by one and wraps from 127 to 0.
- R9: start is ignored outside IDLE, so holding it through a cycle neither changes addr nor restarts the cycle. addr keeps its last value while IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states advance on rising edges, half-state events on falling edges |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a fetch cycle (accepted in IDLE) |
| pc | input | ADDR_W | Program counter to fetch from |
| stall_n | input | 1 | Active-low request to insert wait states |
| din | input | DATA_W | Data bus from memory |
| addr | output | ADDR_W | Address bus |
| fetch_n | output | 1 | Active-low fetch-cycle indicator |
| mem_req_n | output | 1 | Active-low memory request / refresh strobe |
| rd_stb_n | output | 1 | Active-low read strobe |
| refresh_n | output | 1 | Active-low refresh indicator |
| opcode | output | DATA_W | Captured opcode |
| done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
A table of fetches drives different program counters and opcodes with zero, one, two and five wait states. This separates a sequencer that counts stall samples correctly from one that skips or adds a wait state, because the refresh phase would then show up a cycle early or late. Each cycle changes the data bus right after T3 begins, which exposes capture on the wrong edge. Every state is probed in both clock halves to pin down the half-clock strobe edges. Directed runs hold start through a whole cycle, reset in the middle of a cycle, and repeat fetches until the refresh row wraps past 127.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } fstate_e;

endpackage

// File: rtl/opfetch_ctrl.sv
module opfetch_ctrl
    import opfetch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    stall_n,
    output fstate_e state,
    output fstate_e state_neg,
    output fstate_e state_nxt
);

    logic stall_q;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = start ? ST_T1 : ST_IDLE;
            ST_T1:   state_nxt = ST_T2;
            ST_T2,
            ST_TW:   state_nxt = stall_q ? ST_TW : ST_T3;
            ST_T3:   state_nxt = ST_T4;
            ST_T4:   state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // rising-edge state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // falling-edge copy of the state and the stall sample
    always_ff @(negedge clk) begin
        if (rst) begin
            state_neg <= ST_IDLE;
            stall_q   <= 1'b0;
        end else begin
            state_neg <= state;
            if (state == ST_T2 || state == ST_TW)
                stall_q <= !stall_n;
        end
    end

endmodule

// File: rtl/opfetch_rfsh_ctr.sv
module opfetch_rfsh_ctr #(
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [RFSH_W-1:0] row
);

    always_ff @(posedge clk) begin
        if (rst)       row <= '0;
        else if (step) row <= row + 1'b1;
    end

endmodule

// File: rtl/opfetch_strobes.sv
module opfetch_strobes
    import opfetch_pkg::*;
(
    input  fstate_e state,
    input  fstate_e state_neg,
    output logic    fetch_n,
    output logic    mem_req_n,
    output logic    rd_stb_n,
    output logic    refresh_n
);

    logic read_act;
    logic rfsh_req_act;

    always_comb begin
        // read window: second half of T1, then T2 and any wait states
        read_act = ((state == ST_T1) && (state_neg == ST_T1))
                 || (state == ST_T2) || (state == ST_TW);
        // refresh strobe: second half of T3, first half of T4
        rfsh_req_act = ((state == ST_T3) && (state_neg == ST_T3))
                     || ((state == ST_T4) && (state_neg == ST_T3));

        fetch_n   = !((state == ST_T1) || (state == ST_T2) || (state == ST_TW));
        rd_stb_n  = !read_act;
        mem_req_n = !(read_act || rfsh_req_act);
        refresh_n = !((state == ST_T3) || (state == ST_T4));
    end

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
    import opfetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RFSH_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc,
    input  logic              stall_n,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] addr,
    output logic              fetch_n,
    output logic              mem_req_n,
    output logic              rd_stb_n,
    output logic              refresh_n,
    output logic [DATA_W-1:0] opcode,
    output logic              done
);

    localparam int PAD_W = ADDR_W - RFSH_W;

    fstate_e           state;
    fstate_e           state_neg;
    fstate_e           state_nxt;
    logic [RFSH_W-1:0] row;
    logic              enter_t1;
    logic              enter_t3;

    opfetch_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stall_n   (stall_n),
        .state     (state),
        .state_neg (state_neg),
        .state_nxt (state_nxt)
    );

    opfetch_rfsh_ctr #(.RFSH_W(RFSH_W)) u_rfsh (
        .clk  (clk),
        .rst  (rst),
        .step (state == ST_T4),
        .row  (row)
    );

    opfetch_strobes u_strb (
        .state     (state),
        .state_neg (state_neg),
        .fetch_n   (fetch_n),
        .mem_req_n (mem_req_n),
        .rd_stb_n  (rd_stb_n),
        .refresh_n (refresh_n)
    );

    assign enter_t1 = (state == ST_IDLE) && (state_nxt == ST_T1);
    assign enter_t3 = (state != ST_T3) && (state_nxt == ST_T3);

    // address bus, opcode capture and completion pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            opcode <= '0;
            done   <= 1'b0;
        end else begin
            done <= (state == ST_T4);
            if (enter_t1)
                addr <= pc;
            else if (enter_t3) begin
                addr   <= {{PAD_W{1'b0}}, row};
                opcode <= din;
            end
        end
    end

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_n,
    input logic              mem_req_n,
    input logic              rd_stb_n,
    input logic              refresh_n,
    input logic              done,
    input logic [ADDR_W-1:0] addr
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (fetch_n && mem_req_n && rd_stb_n && refresh_n && !done)); // R1

    AST_NO_READ_IN_REFRESH: assert property (@(posedge clk) disable iff (rst)
        !refresh_n |-> rd_stb_n); // R6

    AST_FETCH_PRECEDES_REFRESH: assert property (@(posedge clk) disable iff (rst)
        $fell(refresh_n) |-> $past(!fetch_n)); // R6

    AST_REFRESH_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!refresh_n && $past(!refresh_n)) |-> $stable(addr)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_AFTER_REFRESH: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!refresh_n)); // R8

endmodule

bind opfetch_seq opfetch_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch_n   (fetch_n),
    .mem_req_n (mem_req_n),
    .rd_stb_n  (rd_stb_n),
    .refresh_n (refresh_n),
    .done      (done),
    .addr      (addr)
);

// File: tb/tb_opfetch_seq.sv
module tb_opfetch_seq;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NVEC   = 6;

    // {pc[15:0], opcode[7:0], wait_states[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 8'h3E, 8'd0},
        {16'h1234, 8'hC3, 8'd1},
        {16'hFFFF, 8'h00, 8'd2},
        {16'hA5A5, 8'hFF, 8'd0},
        {16'h8001, 8'h5A, 8'd5},
        {16'h7FFE, 8'hA5, 8'd1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] pc = '0;
    logic              stall_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [ADDR_W-1:0] addr;
    logic              fetch_n, mem_req_n, rd_stb_n, refresh_n, done;
    logic [DATA_W-1:0] opcode;

    int checks = 0;
    int errors = 0;
    int rcnt   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    opfetch_seq dut (
        .clk(clk), .rst(rst), .start(start), .pc(pc), .stall_n(stall_n),
        .din(din), .addr(addr), .fetch_n(fetch_n), .mem_req_n(mem_req_n),
        .rd_stb_n(rd_stb_n), .refresh_n(refresh_n), .opcode(opcode), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strb();
        return {fetch_n, mem_req_n, rd_stb_n, refresh_n};
    endfunction

    // entered at rising edge + 1 with the sequencer idle
    task automatic do_fetch(input logic [15:0] a, input logic [7:0] op,
                            input int nw, input bit hold);
        start = 1'b1;
        pc    = a;
        @(posedge clk); #1;                          // T1 first half
        if (!hold) start = 1'b0;
        chk("R2 addr", addr, a);
        chk("R2 strobes T1a", strb(), 4'b0111);
        #2;                                           // T1 second half
        chk("R3 strobes T1b", strb(), 4'b0001);
        @(posedge clk); #1;                          // T2
        din     = op;
        stall_n = (nw == 0);
        chk("R3 strobes T2", strb(), 4'b0001);
        if (hold) chk("R9 addr held", addr, a);
        for (int k = 0; k < nw; k++) begin
            @(posedge clk); #1;                      // TW
            stall_n = (k == nw - 1);
            chk("R4 strobes TW", strb(), 4'b0001);
        end
        @(posedge clk); #1;                          // T3 first half
        din = ~op;
        chk("R5 strobes T3a", strb(), 4'b1110);
        chk("R6 refresh addr", addr, rcnt);
        #2;
        chk("R7 strobes T3b", strb(), 4'b1010);
        @(posedge clk); #1;                          // T4 first half
        chk("R7 strobes T4a", strb(), 4'b1010);
        chk("R6 addr T4", addr, rcnt);
        #2;
        chk("R7 strobes T4b", strb(), 4'b1110);
        @(posedge clk); #1;                          // cycle after T4
        chk("R8 done", done, 1'b1);
        chk("R5 opcode", opcode, op);
        chk("R1 idle strobes", strb(), 4'b1111);
        chk("R9 addr hold idle", addr, rcnt);
        rcnt = (rcnt + 1) % 128;
        if (hold) start = 1'b0;
        @(posedge clk); #1;
        chk("R8 done single", done, 1'b0);
        chk("R9 no restart", fetch_n, 1'b1);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset strobes", strb(), 4'b1111);
        chk("R1 reset done", done, 1'b0);
        chk("R1 reset addr", addr, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 idle strobes", strb(), 4'b1111);

        for (int i = 0; i < NVEC; i++)
            do_fetch(VEC[i][31:16], VEC[i][15:8], int'(VEC[i][7:0]), 1'b0);

        // R9: start held high during a whole cycle
        do_fetch(16'h4321, 8'h77, 1, 1'b1);

        // R8: run until the refresh row wraps past 127
        while (rcnt != 127) do_fetch(16'h0100 + 16'(rcnt), 8'(rcnt), 0, 1'b0);
        do_fetch(16'h0200, 8'h11, 0, 1'b0);
        chk("R8 wrap", rcnt, 0);
        do_fetch(16'h0201, 8'h22, 0, 1'b0);

        // R1: reset in the middle of a cycle
        start = 1'b1; pc = 16'hBEEF;
        @(posedge clk); #1; start = 1'b0;
        @(posedge clk); #1;                          // T2
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid-cycle reset strobes", strb(), 4'b1111);
        chk("R1 mid-cycle reset done", done, 1'b0);
        #2;
        chk("R1 reset second half", strb(), 4'b1111);
        rst = 1'b0; rcnt = 0;
        @(posedge clk); #1;
        do_fetch(16'h0042, 8'h9C, 2, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule